// File: doc/BRIEF.md
# Saturating Add/Subtract Stage with Sticky Overflow

This block is the arithmetic stage of a fixed-point datapath. Each cycle with `op_valid_i` high it adds or subtracts two two's complement operands. The result goes to one of two destination registers: the result register or the feedback register. The zero, negative, overflow and carry flags are registered in the same cycle.

Two mode bits shape how results and status behave over a sequence of operations. The saturation bit clamps an overflowing result, but only when the result register is the destination. The feedback register always keeps the wrapped value, while the flags still describe the clamped value. The latch bit makes the overflow flag sticky. Once set, it stays set until a status write over the flag bus puts a zero into it.

Every output is registered. An operation presented in one cycle is visible on the outputs after the next rising clock edge.

Top module: `arith_sat_stage`

## Requirements
- R1: While `rst_ni` is low, `res_o`, `fb_o` and `flags_o` are all zero.
- R2: For an operation, the stored value before any clamping is a+b (`op_sub_i`=0) or a-b (`op_sub_i`=1), taken modulo 2^DW. `dst_fb_i`=0 writes it to `res_o` and `dst_fb_i`=1 writes it to `fb_o`. The other register is unchanged.
- R3: `flags_o[3]` (carry) is the carry out of a+b for an add, and the carry out of a+~b+1 for a subtract.
- R4: With `mode_i[2]`=0, `flags_o[2]` (overflow) is set to the signed overflow of each operation and cleared when the operation does not overflow.
- R5: With `mode_i[3]`=1 and `dst_fb_i`=0, an overflowing result is stored as the largest positive value (16'h7FFF at DW=16) if the true result is positive, and as the most negative value (16'h8000) if the true result is negative.
- R6: With `dst_fb_i`=1, `fb_o` receives the wrapped result even when `mode_i[3]`=1.
- R7: `flags_o[0]` (zero) and `flags_o[1]` (negative) describe the saturated value whenever `mode_i[3]`=1, for either destination. With `mode_i[3]`=0 they describe the wrapped value.
- R8: With `mode_i[2]`=1, an overflow sets `flags_o[2]`, and later operations that do not overflow leave it set.
- R9: `flag_wr_i`=1 loads `flag_wdata_i` into `flags_o` at the next edge. The bus write takes priority over an operation in the same cycle, and it is the only way to clear a latched overflow.
- R10: In a cycle with `op_valid_i`=0 and `flag_wr_i`=0, `res_o`, `fb_o` and `flags_o` keep their values whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Perform an operation this cycle |
| op_sub_i | input | 1 | 1 = subtract, 0 = add |
| dst_fb_i | input | 1 | 1 = feedback register, 0 = result register |
| a_i | input | DW (16) | First operand |
| b_i | input | DW (16) | Second operand |
| mode_i | input | MW (8) | Mode status word; bit 3 = saturate, bit 2 = latch overflow |
| flag_wr_i | input | 1 | Bus write strobe for the flags |
| flag_wdata_i | input | 4 | Flag write data {carry, overflow, negative, zero} |
| res_o | output | DW (16) | Result register |
| fb_o | output | DW (16) | Feedback register |
| flags_o | output | 4 | {carry, overflow, negative, zero} |

## Verification
The bench builds the stage at a width of 4 bits and sweeps every pair of operands. The sweep covers both operations, both destinations and all four combinations of the saturation and latch bits. Running every pair through both destinations separates the clamped store from the wrapped store. It also shows that the zero and negative flags follow the clamped value even when the stored value wraps, which only differs at cases such as -8 + -8. Directed sequences then set the sticky overflow and follow it with clean operations. They clear it by a bus write, collide a bus write with an operation, and change the operands during idle cycles.

// File: rtl/arith_sat_pkg.sv
package arith_sat_pkg;
  localparam int FLG_W = 4;
  localparam int FLG_Z = 0;
  localparam int FLG_N = 1;
  localparam int FLG_V = 2;
  localparam int FLG_C = 3;

  typedef struct packed {
    logic c;
    logic v;
    logic n;
    logic z;
  } flags_t;
endpackage

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  output logic [DW-1:0] sum_o,
  output logic          carry_o,
  output logic          ovf_o,
  output logic          neg_true_o
);
  localparam int MSB = DW - 1;

  logic [DW-1:0] b_eff;
  logic [DW:0]   wide;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    wide  = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, sub_i};
  end

  assign sum_o   = wide[DW-1:0];
  assign carry_o = wide[DW];
  // both effective operands share a sign that the sum lost
  assign ovf_o      = (a_i[MSB] == b_eff[MSB]) && (wide[MSB] != a_i[MSB]);
  assign neg_true_o = ovf_o ? a_i[MSB] : wide[MSB];
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] sum_i,
  input  logic          ovf_i,
  input  logic          neg_true_i,
  output logic [DW-1:0] sat_o
);
  localparam logic [DW-1:0] MAX_POS = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MIN_NEG = {1'b1, {(DW-1){1'b0}}};

  always_comb begin
    if (!ovf_i)          sat_o = sum_i;
    else if (neg_true_i) sat_o = MIN_NEG;
    else                 sat_o = MAX_POS;
  end

  always_comb begin
    a_r5_clamp_extreme: assert (!ovf_i || sat_o == MAX_POS || sat_o == MIN_NEG);
  end
endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import arith_sat_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic             latch_i,
  input  logic [DW-1:0]    basis_i,
  input  logic             ovf_i,
  input  logic             carry_i,
  input  logic             wr_i,
  input  logic [FLG_W-1:0] wdata_i,
  output logic [FLG_W-1:0] flags_o
);
  flags_t q, d;

  always_comb begin
    d = q;
    if (wr_i) begin
      d = flags_t'(wdata_i);
    end else if (upd_i) begin
      d.z = (basis_i == '0);
      d.n = basis_i[DW-1];
      d.c = carry_i;
      d.v = latch_i ? (q.v | ovf_i) : ovf_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign flags_o = q;

  a_r8_sticky_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q.v && latch_i && !wr_i) |=> q.v);
  a_r9_bus_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (flags_o == $past(wdata_i)));
  a_r4_ovf_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !latch_i && !wr_i) |=> (q.v == $past(ovf_i)));
endmodule

// File: rtl/arith_sat_stage.sv
module arith_sat_stage
  import arith_sat_pkg::*;
#(
  parameter int DW        = 16,
  parameter int MW        = 8,
  parameter int SAT_BIT   = 3,
  parameter int LATCH_BIT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  logic             op_sub_i,
  input  logic             dst_fb_i,
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    b_i,
  input  logic [MW-1:0]    mode_i,
  input  logic             flag_wr_i,
  input  logic [FLG_W-1:0] flag_wdata_i,
  output logic [DW-1:0]    res_o,
  output logic [DW-1:0]    fb_o,
  output logic [FLG_W-1:0] flags_o
);
  localparam logic [DW-1:0] MAX_POS = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MIN_NEG = {1'b1, {(DW-1){1'b0}}};

  logic          sat_en, latch_en;
  logic [DW-1:0] sum, sat_val, basis;
  logic          carry, ovf, neg_true;
  logic [DW-1:0] res_q, fb_q;

  assign sat_en   = mode_i[SAT_BIT];
  assign latch_en = mode_i[LATCH_BIT];

  addsub_core #(.DW(DW)) u_core (
    .a_i(a_i), .b_i(b_i), .sub_i(op_sub_i),
    .sum_o(sum), .carry_o(carry), .ovf_o(ovf), .neg_true_o(neg_true)
  );

  sat_clamp #(.DW(DW)) u_sat (
    .sum_i(sum), .ovf_i(ovf), .neg_true_i(neg_true), .sat_o(sat_val)
  );

  // flags see the clamped value in saturation mode regardless of destination
  assign basis = sat_en ? sat_val : sum;

  flag_reg #(.DW(DW)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .upd_i(op_valid_i), .latch_i(latch_en),
    .basis_i(basis), .ovf_i(ovf), .carry_i(carry),
    .wr_i(flag_wr_i), .wdata_i(flag_wdata_i),
    .flags_o(flags_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      fb_q  <= '0;
    end else if (op_valid_i) begin
      if (dst_fb_i) fb_q  <= sum;
      else          res_q <= basis;
    end
  end

  assign res_o = res_q;
  assign fb_o  = fb_q;

  a_r5_sat_res: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && sat_en && !dst_fb_i && ovf) |=> (res_o == MAX_POS || res_o == MIN_NEG));
  a_r6_fb_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && dst_fb_i) |=> (fb_o == $past(sum)));
  a_r7_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && sat_en && !flag_wr_i) |=> (flags_o[FLG_Z] == ($past(sat_val) == '0)));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_valid_i && !flag_wr_i) |=> ($stable(res_o) && $stable(fb_o) && $stable(flags_o)));
  a_r2_other_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && dst_fb_i) |=> $stable(res_o));
endmodule

// File: tb/test_arith_sat_stage.sv
`timescale 1ns/1ps
module test_arith_sat_stage;
  localparam int DW = 4;
  localparam int MW = 8;
  localparam int MASK = (1 << DW) - 1;
  localparam int SMAX = (1 << (DW-1)) - 1;
  localparam int SMIN = -(1 << (DW-1));

  logic clk = 0, rst_ni = 0;
  logic op_valid = 0, op_sub = 0, dst_fb = 0, flag_wr = 0;
  logic [DW-1:0] a = '0, b = '0;
  logic [MW-1:0] mode = '0;
  logic [3:0] flag_wdata = '0;
  logic [DW-1:0] res, fb;
  logic [3:0] flags;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_res = 0, m_fb = 0, m_flags = 0;

  always #2.5 clk = ~clk;

  arith_sat_stage #(.DW(DW), .MW(MW)) i_arith_sat_stage (
    .clk_i(clk), .rst_ni(rst_ni), .op_valid_i(op_valid), .op_sub_i(op_sub),
    .dst_fb_i(dst_fb), .a_i(a), .b_i(b), .mode_i(mode),
    .flag_wr_i(flag_wr), .flag_wdata_i(flag_wdata),
    .res_o(res), .fb_o(fb), .flags_o(flags)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int sx(int v);
    return (v & (1 << (DW-1))) ? v - (1 << DW) : v;
  endfunction

  // reference update for one operation (bus write handled by caller)
  task automatic model_op(bit sub, bit dst, int av, int bv, bit sat, bit lat);
    int tr, wr, sv, basis, cy, ov, fl;
    tr = sub ? sx(av) - sx(bv) : sx(av) + sx(bv);
    wr = tr & MASK;
    ov = (tr > SMAX || tr < SMIN) ? 1 : 0;
    sv = ov ? ((tr > 0 ? SMAX : SMIN) & MASK) : wr;
    cy = sub ? ((av + ((~bv) & MASK) + 1) >> DW) & 1 : ((av + bv) >> DW) & 1;
    basis = sat ? sv : wr;
    if (dst) m_fb = wr; else m_res = basis;
    fl = (basis == 0 ? 1 : 0) | (((basis >> (DW-1)) & 1) << 1) | (cy << 3);
    fl |= ((lat ? (((m_flags >> 2) & 1) | ov) : ov) << 2);
    m_flags = fl;
  endtask

  task automatic drive_op(bit sub, bit dst, int av, int bv, bit sat, bit lat);
    @(negedge clk);
    op_valid = 1; op_sub = sub; dst_fb = dst;
    a = DW'(av); b = DW'(bv);
    mode = '0; mode[3] = sat; mode[2] = lat;
    @(negedge clk);
    op_valid = 0;
    model_op(sub, dst, av, bv, sat, lat);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 res", int'(res), 0);
    check("R1 fb", int'(fb), 0);
    check("R1 flags", int'(flags), 0);
    rst_ni = 1;

    // exhaustive sweep
    for (int lat = 0; lat < 2; lat++)
      for (int sat = 0; sat < 2; sat++)
        for (int dst = 0; dst < 2; dst++)
          for (int sub = 0; sub < 2; sub++)
            for (int av = 0; av <= MASK; av++)
              for (int bv = 0; bv <= MASK; bv++) begin
                drive_op(sub[0], dst[0], av, bv, sat[0], lat[0]);
                if (dst != 0) check("R6 fb wrap", int'(fb), m_fb);
                else check(sat != 0 ? "R2/R5 res" : "R2 res", int'(res), m_res);
                check("R2 other reg kept", dst != 0 ? int'(res) : int'(fb), dst != 0 ? m_res : m_fb);
                check("R3/R4/R7/R8 flags", int'(flags), m_flags);
              end

    // R8: sticky overflow survives clean ops
    drive_op(0, 0, 7, 1, 0, 1);
    check("R8 ovf set", int'(flags[2]), 1);
    drive_op(0, 0, 1, 1, 0, 1);
    drive_op(1, 1, 3, 1, 1, 1);
    check("R8 ovf held", int'(flags[2]), 1);
    // R4: without latch a clean op clears it
    drive_op(0, 0, 1, 1, 0, 0);
    check("R4 ovf cleared", int'(flags[2]), 0);

    // R9: bus write clears latched overflow
    drive_op(0, 0, 7, 1, 0, 1);
    @(negedge clk); flag_wr = 1; flag_wdata = 4'h0;
    @(negedge clk); flag_wr = 0; m_flags = 0;
    check("R9 write zero", int'(flags), 0);
    drive_op(0, 0, 1, 1, 0, 1);
    check("R9 stays clear", int'(flags[2]), 0);
    // R9: write wins over simultaneous op
    @(negedge clk);
    flag_wr = 1; flag_wdata = 4'hA; op_valid = 1; op_sub = 0; dst_fb = 0;
    a = 4'd7; b = 4'd7; mode = 8'h0C;
    @(negedge clk);
    flag_wr = 0; op_valid = 0;
    model_op(0, 0, 7, 7, 1, 1);
    m_flags = 'hA;
    check("R9 priority flags", int'(flags), 'hA);
    check("R9 op still stores res", int'(res), m_res);

    // R10: idle cycles with changing operands
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); a = DW'(k * 3); b = DW'(k + 5); op_sub = k[0]; mode = 8'hFF;
    end
    @(negedge clk);
    check("R10 res hold", int'(res), m_res);
    check("R10 fb hold", int'(fb), m_fb);
    check("R10 flags hold", int'(flags), m_flags);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1-all actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
  end
endmodule